// File: doc/BRIEF.md
# Tag-Only Set-Associative Cache Profiler

This block predicts whether each address in a stream would hit or miss in a set-associative cache. It holds only tags and valid bits and never stores data. A monitor or trace engine presents at most one address per cycle with a strobe. One cycle later the block returns a hit or miss flag. It also keeps two running totals: requests seen and misses seen.

Each address splits into three fields: a block offset, a set index taken from the bits just above the offset, and a tag. The tag is the address with the offset and set bits forced to zero. It is stored and compared at full address width. Every way of the selected set is probed in parallel.

On a miss the new tag goes into the lowest-numbered empty way of the set. When the set has no empty way, a pseudo-random way is overwritten. A hit changes nothing, so the block keeps no recency history.

Top module: `tag_cache_profiler`

## Requirements
- R1: With the default geometry (8 ways, 64-byte blocks, 16384 bytes in total, so 32 sets), the offset is `req_addr[5:0]`, the set index is `req_addr[10:6]` and the tag is `req_addr` with bits 10..0 cleared. Two addresses that differ only in offset bits refer to the same block.
- R2: A request hits exactly when some way of its set is valid and holds a tag equal to the request's tag. Otherwise it misses.
- R3: On a miss into a set that has an empty way, the lowest-numbered empty way takes the new tag and becomes valid. No other way of that set is disturbed.
- R4: On a miss into a full set, the way overwritten is the low 3 bits of a 16-bit LFSR. After reset the LFSR holds 16'hACE1. It advances on every clock edge outside reset, shifting left with a new bit 0 equal to bit15 ^ bit13 ^ bit12 ^ bit10. The value used is the one held in the cycle the request is presented.
- R5: A hit leaves every tag and valid bit unchanged.
- R6: `res_valid` is high in the cycle after a request and low in the cycle after a cycle with no request. `res_hit` holds that request's result.
- R7: `access_count` rises by one per request and `miss_count` rises by one per miss. Both become visible in the same cycle as `res_valid`.
- R8: A request in the cycle right after a miss sees the allocation that miss made.
- R9: Synchronous reset clears every valid bit, both counters and `res_valid`, and reseeds the LFSR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_addr | input | ADDR_W (32) | Request address |
| res_valid | output | 1 | Result strobe, one cycle after the request |
| res_hit | output | 1 | 1 = hit, 0 = miss |
| access_count | output | CNT_W (32) | Total requests since reset |
| miss_count | output | CNT_W (32) | Total misses since reset |

## Verification
A wrong tag, valid bit or victim choice does not show at once. It shows later, as a mismatched `res_hit` on a following request to the same set, and `miss_count` drifts from that point on. Bad allocation therefore shows within a few requests when a small set of tags is reused. A bad victim only shows when the evicted tag or a kept tag is probed again. For that reason the stimulus packs more tags than ways into a few sets and repeats them often. Counter and strobe faults show in the very cycle after the request.

// File: rtl/tag_cache_profiler.sv
module tag_cache_profiler #(
  parameter int ADDR_W      = 32,
  parameter int WAYS        = 8,
  parameter int BLOCK_BYTES = 64,
  parameter int TOTAL_BYTES = 16384,
  parameter int CNT_W       = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              res_valid,
  output logic              res_hit,
  output logic [CNT_W-1:0]  access_count,
  output logic [CNT_W-1:0]  miss_count
);
  localparam int SETS  = TOTAL_BYTES / (BLOCK_BYTES * WAYS);
  localparam int OFF_W = $clog2(BLOCK_BYTES);
  localparam int SET_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam logic [ADDR_W-1:0] TAG_MASK = {ADDR_W{1'b1}} << (OFF_W + SET_W);

  logic [ADDR_W-1:0] tags [SETS][WAYS];
  logic [WAYS-1:0]   vld  [SETS];
  logic [15:0]       lfsr;

  logic [SET_W-1:0]  set_idx;
  logic [ADDR_W-1:0] tag;
  logic [WAYS-1:0]   hit_vec;
  logic [WAY_W-1:0]  free_way;
  logic [WAY_W-1:0]  victim;
  logic              hit;

  assign set_idx = req_addr[OFF_W +: SET_W];
  assign tag     = req_addr & TAG_MASK;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign hit_vec[w] = vld[set_idx][w] && (tags[set_idx][w] == tag);
  end

  assign hit = |hit_vec;

  always_comb begin
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--)
      if (!vld[set_idx][w]) free_way = WAY_W'(w);
  end

  assign victim = (&vld[set_idx]) ? lfsr[WAY_W-1:0] : free_way;

  always_ff @(posedge clk) begin
    if (rst) lfsr <= 16'hACE1;
    else     lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) vld[s] <= '0;
    end else if (req_valid && !hit) begin
      vld[set_idx][victim]  <= 1'b1;
      tags[set_idx][victim] <= tag;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid    <= 1'b0;
      res_hit      <= 1'b0;
      access_count <= '0;
      miss_count   <= '0;
    end else begin
      res_valid <= req_valid;
      if (req_valid) begin
        res_hit      <= hit;
        access_count <= access_count + 1'b1;
        if (!hit) miss_count <= miss_count + 1'b1;
      end
    end
  end

  AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> $onehot0(hit_vec)); // R2
  AST_RESULT_NEXT: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> res_valid); // R6
  AST_RESULT_IDLE: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !res_valid); // R6
  AST_ACCESS_STEP: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> access_count == $past(access_count) + 1'b1); // R7
  AST_MISS_STEP: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !hit) |=> miss_count == $past(miss_count) + 1'b1); // R7
  AST_HIT_KEEPS_SET: assert property (@(posedge clk) disable iff (rst)
    (req_valid && hit) |=> vld[$past(set_idx)] == $past(vld[set_idx])); // R5
  AST_MISS_LE_ACCESS: assert property (@(posedge clk) disable iff (rst)
    miss_count <= access_count); // R7
endmodule

// File: tb/tag_cache_profiler_bench.sv
module tag_cache_profiler_bench;
  localparam int SETS = 32;
  localparam int WAYS = 8;
  localparam logic [31:0] MASK = 32'hFFFF_F800;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic res_valid, res_hit;
  logic [31:0] access_count, miss_count;

  always #2.5 clk = ~clk;

  tag_cache_profiler u_tag_cache_profiler (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .res_valid(res_valid), .res_hit(res_hit),
    .access_count(access_count), .miss_count(miss_count)
  );

  logic [15:0] m_lfsr;
  always @(posedge clk)
    if (rst) m_lfsr <= 16'hACE1;
    else     m_lfsr <= {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};

  logic [31:0] mt [SETS][WAYS];
  logic        mv [SETS][WAYS];
  int unsigned e_acc, e_miss;
  int vectors = 0, errors = 0;
  bit done = 0;

  task automatic model_clear();
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) mv[s][w] = 1'b0;
    e_acc = 0; e_miss = 0;
  endtask

  function automatic bit model_hit(input logic [31:0] a);
    int s = int'(a[10:6]);
    for (int w = 0; w < WAYS; w++)
      if (mv[s][w] && mt[s][w] == (a & MASK)) return 1'b1;
    return 1'b0;
  endfunction

  task automatic cmp(input string rq, input string what, input logic [31:0] got, input logic [31:0] exp);
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, got, exp);
    end
  endtask

  task automatic step(input logic v, input logic [31:0] a, input string rq);
    bit h = 1'b0;
    @(negedge clk);
    req_valid = v; req_addr = a;
    if (v) begin
      int s = int'(a[10:6]);
      int vic = -1;
      h = model_hit(a);
      e_acc++;
      if (!h) begin
        e_miss++;
        for (int w = WAYS - 1; w >= 0; w--) if (!mv[s][w]) vic = w;
        if (vic < 0) vic = int'(m_lfsr[2:0]);
        mv[s][vic] = 1'b1; mt[s][vic] = a & MASK;
      end
    end
    @(posedge clk); #1;
    vectors++;
    cmp(rq, "res_valid", 32'(res_valid), 32'(v));
    if (v) cmp(rq, "res_hit", 32'(res_hit), 32'(h));
    cmp(rq, "access_count", access_count, e_acc);
    cmp(rq, "miss_count", miss_count, e_miss);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; req_valid = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    model_clear();
    #1; vectors++;
    cmp("R9", "res_valid", 32'(res_valid), 32'd0);
    cmp("R9", "access_count", access_count, 32'd0);
    cmp("R9", "miss_count", miss_count, 32'd0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5678));
    do_reset();
    step(1, 32'h0000_0040, "R1");
    step(1, 32'h0000_007F, "R1");
    step(1, 32'h0000_0080, "R1");
    step(1, 32'h0000_0840, "R1");
    step(0, 32'h0000_0040, "R6");
    step(1, 32'h0000_0040, "R5");
    for (int t = 0; t < WAYS; t++) step(1, (32'(t) << 11) | 32'h140, "R3");
    for (int t = 0; t < WAYS; t++) step(1, (32'(t) << 11) | 32'h145, "R2");
    for (int k = 0; k < 4; k++) begin
      step(1, (32'(WAYS + k) << 11) | 32'h140, "R4");
      for (int t = 0; t < WAYS + k + 1; t++) step(1, (32'(t) << 11) | 32'h140, "R4");
    end
    step(1, 32'h0012_3440, "R8");
    step(1, 32'h0012_3440, "R8");
    step(1, 32'h0045_6440, "R8");
    step(0, 32'h0, "R6");
    do_reset();
    step(1, 32'h0000_0040, "R9");
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] a;
      a = ($urandom_range(0, 11) << 11) | ($urandom_range(0, 3) << 6) | $urandom_range(0, 63);
      step(($urandom_range(0, 4) != 0), a, "R2");
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule